// File: doc/BRIEF.md
# Saturating Dual Add-Subtract ALU

This is a 32-bit integer arithmetic unit for a signal-processing datapath. Each cycle it can accept two register operands, X and Y, with an opcode. It can add them, subtract them, or produce both the sum and the difference in the same cycle. It can also compare them, clamp X to a symmetric window set by Y, or pick between X and Y according to the condition flags. The unit sits between the operand read ports and the write-back stage. A strobe marks each operation, and the registered results and flags appear exactly one cycle later.

A mode input selects saturating or wrapping arithmetic. In saturating mode, a signed overflow clamps the result to the largest positive or most negative value, whichever has the correct sign. In wrapping mode, the result is taken modulo 2^32. In both modes the overflow flag reports the event. A compare loads a small condition-flag register. A later conditional select reads that register to decide whether the alternate operand replaces the normal one.

Top module: `sat_alu`

## Requirements
- R1: `out_valid` rises exactly one cycle after each cycle with `in_valid` high and is low otherwise. After reset, `out_valid` is 0 and the condition-flag register is cleared.
- R2: Opcode 3'd0 (ADD) writes X+Y to `res_a`. With `sat_en` low the result wraps. `flag_v` marks signed overflow and `flag_c` is the unsigned carry out of bit 31.
- R3: Opcode 3'd1 (SUB) writes X-Y to `res_a`. `flag_v` marks signed overflow and `flag_c` is 1 when no borrow occurs (X >= Y unsigned).
- R4: With `sat_en` high, a signed overflow in ADD or SUB returns 0x7FFFFFFF for a positive overflow and 0x80000000 for a negative one. `flag_v` is still set.
- R5: Opcode 3'd2 (DUAL) writes X+Y to `res_a` and X-Y to `res_b` in the same output cycle. Each result saturates on its own. `flag_v`/`flag_c` describe the sum, and `ovf_b` marks overflow of the difference.
- R6: Opcode 3'd4 (CLIP) writes X limited to the signed range [-|Y|, +|Y|]. When Y = 0x80000000 the limit is 0x7FFFFFFF. `flag_v` and `flag_c` are 0.
- R7: Opcode 3'd3 (CMP) writes the wrapped X-Y to `res_a` whatever `sat_en` is. Its Z, N, V, C flags are output and also loaded into the condition-flag register.
- R8: Opcode 3'd5 (CSEL) writes Y when the condition named by `cond` holds on the condition-flag register, and X otherwise. The condition codes are 0 = EQ (Z), 1 = LT (N xor V), 2 = LE (Z or (N xor V)), 3 = always.
- R9: No opcode other than CMP changes the condition-flag register.
- R10: For every defined opcode, `flag_z` is 1 exactly when `res_a` is zero and `flag_n` equals bit 31 of `res_a`.
- R11: Opcodes 3'd6 and 3'd7 are reserved. They produce zero results and all flags 0.
- R12: `res_b` and `ovf_b` are 0 for every opcode other than DUAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode valid this cycle |
| op | input | 3 | Operation code |
| cond | input | 2 | Condition code for CSEL |
| sat_en | input | 1 | 1 = saturating arithmetic, 0 = wrapping |
| opx | input | 32 | Operand X |
| opy | input | 32 | Operand Y |
| out_valid | output | 1 | Results valid |
| res_a | output | 32 | Primary result |
| res_b | output | 32 | Difference result of DUAL |
| flag_z | output | 1 | Primary result is zero |
| flag_n | output | 1 | Primary result is negative |
| flag_v | output | 1 | Signed overflow of primary operation |
| flag_c | output | 1 | Carry / no-borrow of primary operation |
| ovf_b | output | 1 | Signed overflow of DUAL difference |

## Verification
The embedded properties assume that the operands and mode on a strobed cycle are settled before the capturing edge. They also assume that nothing but reset disturbs the condition-flag register, so every conditional select is judged against the last compare actually issued. The stimulus changes inputs only on the falling clock edge. Its reference model tracks its own copy of the condition flags, updated in issue order, and the directed cases place each select directly after a known compare or after a non-compare operation. The directed cases cover values next to both extremes, including Y at the most negative value for CLIP. The random operations are drawn only from defined and reserved opcodes.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [1:0]   cond,
  input  logic         sat_en,
  input  logic [W-1:0] opx,
  input  logic [W-1:0] opy,
  output logic         out_valid,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_c,
  output logic         ovf_b
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_DUAL = 3'd2,
                         OP_CMP = 3'd3, OP_CLIP = 3'd4, OP_CSEL = 3'd5;

  logic [W:0]   sum_w, dif_w;
  logic         sum_v, dif_v;
  logic [W-1:0] sum_s, dif_s;
  logic [W-1:0] lim, neg_lim, clip_r;
  logic         cz, cn, cv, cc;
  logic         take_y;
  logic [W-1:0] na, nb;
  logic         nv, nc, nvb, known;

  assign sum_w = {1'b0, opx} + {1'b0, opy};
  assign dif_w = {1'b0, opx} + {1'b0, ~opy} + (W+1)'(1);
  assign sum_v = (opx[W-1] == opy[W-1]) && (sum_w[W-1] != opx[W-1]);
  assign dif_v = (opx[W-1] != opy[W-1]) && (dif_w[W-1] != opx[W-1]);
  assign sum_s = (sat_en && sum_v) ? (opx[W-1] ? MINV : MAXV) : sum_w[W-1:0];
  assign dif_s = (sat_en && dif_v) ? (opx[W-1] ? MINV : MAXV) : dif_w[W-1:0];

  assign lim     = (opy == MINV) ? MAXV : (opy[W-1] ? (~opy + 1'b1) : opy);
  assign neg_lim = ~lim + 1'b1;
  assign clip_r  = ($signed(opx) > $signed(lim))     ? lim :
                   ($signed(opx) < $signed(neg_lim)) ? neg_lim : opx;

  always_comb begin
    case (cond)
      2'd0:    take_y = cz;
      2'd1:    take_y = cn ^ cv;
      2'd2:    take_y = cz | (cn ^ cv);
      default: take_y = 1'b1;
    endcase
  end

  always_comb begin
    na = '0; nb = '0; nv = 1'b0; nc = 1'b0; nvb = 1'b0; known = 1'b1;
    case (op)
      OP_ADD:  begin na = sum_s; nv = sum_v; nc = sum_w[W]; end
      OP_SUB:  begin na = dif_s; nv = dif_v; nc = dif_w[W]; end
      OP_DUAL: begin
        na = sum_s; nv = sum_v; nc = sum_w[W];
        nb = dif_s; nvb = dif_v;
      end
      OP_CMP:  begin na = dif_w[W-1:0]; nv = dif_v; nc = dif_w[W]; end
      OP_CLIP: na = clip_r;
      OP_CSEL: na = take_y ? opy : opx;
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_a <= '0; res_b <= '0;
      flag_z <= 1'b0; flag_n <= 1'b0; flag_v <= 1'b0; flag_c <= 1'b0; ovf_b <= 1'b0;
      cz <= 1'b0; cn <= 1'b0; cv <= 1'b0; cc <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_a  <= na;
        res_b  <= nb;
        flag_z <= known && (na == '0);
        flag_n <= known && na[W-1];
        flag_v <= nv;
        flag_c <= nc;
        ovf_b  <= nvb;
        if (op == OP_CMP) begin
          cz <= (dif_w[W-1:0] == '0);
          cn <= dif_w[W-1];
          cv <= dif_v;
          cc <= dif_w[W];
        end
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_sat_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && (op == OP_ADD) && sum_v) |=> (res_a == MAXV || res_a == MINV) && flag_v);
  p_dual_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_en && (op == OP_DUAL)) |=> (res_a - res_b) == ($past(opy) << 1));
  p_clip_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_CLIP)) |=>
      ($signed(res_a) <= $signed($past(lim))) && ($signed(res_a) >= -$signed($past(lim))));
  p_cflags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (op == OP_CMP)) |=> $stable({cz, cn, cv, cc}));
  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && known) |=> flag_z == (res_a == '0));
  p_side_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op != OP_DUAL)) |=> (res_b == '0) && !ovf_b);

endmodule

// File: tb/sat_alu_test.sv
module sat_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  cond = '0;
  logic        sat_en = 1'b0;
  logic [31:0] opx = '0, opy = '0;
  logic        out_valid;
  logic [31:0] res_a, res_b;
  logic        flag_z, flag_n, flag_v, flag_c, ovf_b;

  always #2 clk = ~clk;

  sat_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cond(cond),
    .sat_en(sat_en), .opx(opx), .opy(opy), .out_valid(out_valid), .res_a(res_a),
    .res_b(res_b), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
    .ovf_b(ovf_b));

  typedef struct {
    logic [31:0] a, b;
    logic z, n, v, c, vb;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic mz = 0, mn = 0, mv = 0, mc = 0;
  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  function automatic void arith(input logic [31:0] x, y, input bit sub, input bit sat,
                                output logic [31:0] r, output logic v, c);
    longint full;
    logic [32:0] u;
    full = sub ? (longint'($signed(x)) - longint'($signed(y)))
               : (longint'($signed(x)) + longint'($signed(y)));
    v = (full > MAXL) || (full < MINL);
    r = full[31:0];
    if (sat && v) r = (full > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
    u = {1'b0, x} + {1'b0, y};
    c = sub ? (x >= y) : u[32];
  endfunction

  task automatic issue(input logic [2:0] o, input logic [1:0] cd, input bit s,
                       input logic [31:0] x, y, input string rq);
    exp_t e;
    logic t;
    longint lim, sx;
    e.a = '0; e.b = '0; e.v = 0; e.c = 0; e.vb = 0; e.req = rq;
    case (o)
      3'd0: arith(x, y, 0, s, e.a, e.v, e.c);
      3'd1: arith(x, y, 1, s, e.a, e.v, e.c);
      3'd2: begin
        arith(x, y, 0, s, e.a, e.v, e.c);
        arith(x, y, 1, s, e.b, e.vb, t);
      end
      3'd3: begin
        arith(x, y, 1, 0, e.a, e.v, e.c);
      end
      3'd4: begin
        lim = longint'($signed(y));
        if (lim < 0) lim = -lim;
        if (lim > MAXL) lim = MAXL;
        sx = longint'($signed(x));
        e.a = (sx > lim) ? lim[31:0] : (sx < -lim) ? 32'(-lim) : x;
      end
      3'd5: begin
        case (cd)
          2'd0: t = mz;
          2'd1: t = mn ^ mv;
          2'd2: t = mz | (mn ^ mv);
          default: t = 1'b1;
        endcase
        e.a = t ? y : x;
      end
      default: ;
    endcase
    e.z = (o <= 3'd5) && (e.a == 0);
    e.n = (o <= 3'd5) && e.a[31];
    if (o == 3'd3) begin mz = e.z; mn = e.n; mv = e.v; mc = e.c; end
    @(negedge clk);
    in_valid = 1'b1; op = o; cond = cd; sat_en = s; opx = x; opy = y;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  task automatic chk(input bit ok, input string what, input string rq, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) chk(0, "unexpected out_valid", "R1", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(res_a == e.a, "res_a", e.req, res_a, e.a);
        chk(res_b == e.b, "res_b", e.req, res_b, e.b);
        chk({flag_z, flag_n, flag_v, flag_c, ovf_b} == {e.z, e.n, e.v, e.c, e.vb},
            "flags zvncb", e.req, 32'({flag_z, flag_n, flag_v, flag_c, ovf_b}),
            32'({e.z, e.n, e.v, e.c, e.vb}));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=0", q.size());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && res_a == 0, "reset state", "R1", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    idle(2);
    // R1: nothing issued, nothing out
    chk(out_valid == 0, "idle valid", "R1", 32'(out_valid), 32'd0);
    // R8 after reset: flags clear, EQ false -> X
    issue(3'd5, 2'd0, 0, 32'd11, 32'd22, "R8");
    // R2 plain and wrapping overflow, carry
    issue(3'd0, 0, 0, 32'd5, 32'd7, "R2");
    issue(3'd0, 0, 0, 32'h7FFF_FFFF, 32'd1, "R2");
    issue(3'd0, 0, 0, 32'hFFFF_FFFF, 32'd1, "R2 R10");
    // R4 saturation both signs
    issue(3'd0, 0, 1, 32'h7FFF_FFF0, 32'h100, "R4");
    issue(3'd0, 0, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
    idle(1);
    // R3 sub borrow and overflow
    issue(3'd1, 0, 0, 32'd3, 32'd9, "R3");
    issue(3'd1, 0, 0, 32'h8000_0000, 32'd1, "R3");
    issue(3'd1, 0, 1, 32'h8000_0000, 32'd1, "R3 R4");
    issue(3'd1, 0, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R4");
    // R5 dual with independent saturation
    issue(3'd2, 0, 0, 32'd100, 32'd30, "R5");
    issue(3'd2, 0, 1, 32'h7FFF_FFF0, 32'h20, "R5");
    issue(3'd2, 0, 1, 32'h8000_0010, 32'h20, "R5");
    issue(3'd2, 0, 0, 32'h8000_0010, 32'h20, "R5");
    // R6 clip
    issue(3'd4, 0, 0, 32'd500, 32'd100, "R6");
    issue(3'd4, 0, 0, -32'sd500, 32'd100, "R6");
    issue(3'd4, 0, 0, 32'd50, -32'sd100, "R6");
    issue(3'd4, 0, 0, 32'd500, -32'sd100, "R6");
    issue(3'd4, 0, 0, 32'h8000_0000, 32'h8000_0000, "R6");
    issue(3'd4, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, "R6");
    // R7 compare ignores sat, then R8 selects
    issue(3'd3, 0, 1, 32'h8000_0000, 32'd1, "R7");
    issue(3'd5, 2'd1, 0, 32'd1, 32'd2, "R8");
    issue(3'd3, 0, 0, 32'd7, 32'd7, "R7");
    issue(3'd5, 2'd0, 0, 32'd1, 32'd2, "R8");
    issue(3'd5, 2'd2, 0, 32'd1, 32'd2, "R8");
    issue(3'd5, 2'd1, 0, 32'd1, 32'd2, "R8");
    issue(3'd3, 0, 0, 32'd9, 32'd4, "R7");
    issue(3'd5, 2'd2, 0, 32'd1, 32'd2, "R8");
    issue(3'd5, 2'd3, 0, 32'd1, 32'd2, "R8");
    // R9 overflowing ADD must not disturb condition flags (still 9>4)
    issue(3'd0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
    issue(3'd1, 0, 0, 32'd0, 32'd0, "R9");
    issue(3'd5, 2'd2, 0, 32'd1, 32'd2, "R9");
    // R11 reserved, then confirm flags unchanged
    issue(3'd6, 0, 1, 32'd4, 32'd4, "R11");
    issue(3'd7, 0, 0, 32'hFFFF_FFFF, 32'd1, "R11");
    issue(3'd5, 2'd0, 0, 32'd1, 32'd2, "R11 R9");
    idle(2);
    // random mix covering R10 R12
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rx, ry;
      rx = $urandom; ry = $urandom;
      if (i % 5 == 0) rx = {rx[31], {31{~rx[31]}}} ^ 32'($urandom_range(0, 3));
      issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            rx, ry, "R10 R12");
      if (i % 17 == 0) idle(1);
    end
    idle(3);
    chk(q.size() == 0, "queue drained", "R1", 32'(q.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule